// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on the master clock and watches the word-rate clock (the left/right frame clock, one period per sample). It counts master-clock cycles between successive rising edges of the frame clock and decides whether the master clock runs at 256, 384 or 512 times the sample rate. Once the same ratio has been measured over two consecutive frames, it reports the ratio and raises a ready flag. It then issues a single-cycle clock enable whose average rate is always 256 times the sample rate. For a 256x master clock the enable is high on every cycle, for 384x on two cycles out of three, and for 512x on every other cycle.

A synchronous active-low run input forces the block idle. The block also drives a hold output that keeps the rest of the device powered down until both clocks are running and a valid ratio is locked. If no frame edge arrives within a fixed number of master cycles, the block drops ready and goes back to waiting.

The controller has five states. ST_OFF is the idle state while run is low. ST_WAIT waits for the first frame edge. ST_MEASURE times the first full frame. ST_CONFIRM holds one candidate ratio. ST_LOCKED is the running state. The transitions are:
- OFF to WAIT when run is high.
- WAIT to MEASURE on a frame edge.
- MEASURE to CONFIRM on an edge that ends a frame of valid length.
- CONFIRM to LOCKED on an edge that repeats the candidate ratio.
- CONFIRM back to MEASURE on an edge that ends a frame of invalid length.
- LOCKED to CONFIRM when a frame of a different valid ratio arrives.
- LOCKED to MEASURE when a frame of invalid length arrives.
- MEASURE, CONFIRM or LOCKED back to WAIT on timeout.
- Any state to OFF when run is low.

Top module: `mclk_ratio_detect`

## Requirements
- R1: After reset, ready is 0, ratio is 2'b11, clk_en is 0 and hold_pd is 1.
- R2: A frame of 256±2, 384±2 or 512±2 master cycles, seen on two consecutive frames, gives ready=1 and ratio equal to 2'b00, 2'b01 or 2'b10 respectively.
- R3: Frame lengths outside every tolerance window never give ready; ratio stays 2'b11.
- R4: Ready rises only on the third frame rising edge after leaving ST_WAIT. A single valid frame is not enough.
- R5: While locked, clk_en is high on every cycle for 256x. For 384x it is high on two cycles of every three, with never two low cycles in a row. For 512x it alternates every cycle.
- R6: clk_en is 0 whenever ready is 0.
- R7: With no frame rising edge for 1024 master cycles, ready drops to 0. A gap shorter than that keeps ready high.
- R8: While run is low, ready and clk_en are 0 from the next cycle on, whatever the frame clock does.
- R9: hold_pd is 1 exactly when ready is 0.
- R10: Lock does not depend on the phase of the frame clock relative to the master clock or to the release of run.
- R11: A change to a different valid ratio while locked leads to a new lock on the new ratio code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Reset, active low |
| run | input | 1 | Synchronous power-down, active low (0 = idle) |
| lr_clk | input | 1 | Frame (word-rate) clock, asynchronous to clk |
| clk_en | output | 1 | Single-cycle enable at 256 times the sample rate |
| ratio | output | 2 | 00=256x, 01=384x, 10=512x, 11=invalid |
| ready | output | 1 | Ratio locked |
| hold_pd | output | 1 | Keeps the rest of the device powered down |

## Verification
Directed runs at the three nominal frame lengths show that each ratio lands on its own code. They also check that ready is still low after the second edge and high after the third. An enable count over a 24-cycle window then tells apart the every-cycle, two-in-three and every-other patterns. Randomised runs pick one of the three nominal lengths and add an offset of up to six cycles, with a random start delay. Offsets within two must lock to the right code, and larger ones must leave ready and clk_en low. This tells the tolerance window apart from a looser or tighter one, independent of phase. Targeted runs stop the frame clock to trip the timeout, switch from 256x to 384x while locked, and lower run while the frame clock keeps going.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_MEASURE,
        ST_CONFIRM,
        ST_LOCKED
    } mrd_state_t;

    localparam logic [1:0] RT_256 = 2'b00;
    localparam logic [1:0] RT_384 = 2'b01;
    localparam logic [1:0] RT_512 = 2'b10;
    localparam logic [1:0] RT_BAD = 2'b11;

endpackage

// File: rtl/mrd_lr_sync.sv
module mrd_lr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lr_in,
    output logic rise_o
);

    // sh[STAGES-1:0] is the synchroniser chain; sh[STAGES] is the edge register
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], lr_in};
        end
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/mrd_period_cnt.sv
module mrd_period_cnt #(
    parameter int TIMEOUT = 1024,
    parameter int CW      = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rise,
    output logic [CW-1:0] meas_o,
    output logic          tmo_o
);

    localparam logic [CW-1:0] TMO_V = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (rise) begin
            cnt <= CW'(1);
        end else if (cnt != TMO_V) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign meas_o = cnt;
    assign tmo_o  = (cnt == TMO_V);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TMO_V); // R7

endmodule

// File: rtl/mrd_classify.sv
module mrd_classify
    import mrd_pkg::*;
#(
    parameter int BASE = 256,
    parameter int TOL  = 2,
    parameter int CW   = 11
) (
    input  logic [CW-1:0] meas,
    output logic [1:0]    code_o
);

    localparam int NRAT = 3;

    logic [NRAT-1:0] hit;

    // window gi is centred on BASE*(2+gi)/2: 1x, 1.5x, 2x the internal rate
    for (genvar gi = 0; gi < NRAT; gi++) begin : g_win
        localparam int NOM = BASE * (2 + gi) / 2;
        localparam logic [CW-1:0] LO = CW'(NOM - TOL);
        localparam logic [CW-1:0] HI = CW'(NOM + TOL);
        assign hit[gi] = (meas >= LO) && (meas <= HI);
    end

    always_comb begin
        code_o = RT_BAD;
        if (hit[0]) begin
            code_o = RT_256;
        end else if (hit[1]) begin
            code_o = RT_384;
        end else if (hit[2]) begin
            code_o = RT_512;
        end
    end

endmodule

// File: rtl/mrd_en_gen.sv
module mrd_en_gen
    import mrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] code,
    output logic       en_o
);

    logic [1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!active) begin
            ph <= '0;
        end else begin
            unique case (code)
                RT_384:  ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
                RT_512:  ph <= {1'b0, ~ph[0]};
                default: ph <= '0;
            endcase
        end
    end

    always_comb begin
        en_o = 1'b0;
        if (active) begin
            unique case (code)
                RT_256:  en_o = 1'b1;
                RT_384:  en_o = (ph != 2'd2);
                RT_512:  en_o = (ph == 2'd0);
                default: en_o = 1'b0;
            endcase
        end
    end

    AST_384_NO_DOUBLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && code == RT_384 && $past(code) == RT_384 && !en_o)
        |-> $past(en_o)); // R5

    AST_512_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && code == RT_512 && $past(code) == RT_512)
        |-> (en_o != $past(en_o))); // R5

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int BASE       = 256,
    parameter int TOL        = 2,
    parameter int TIMEOUT    = 1024,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       lr_clk,
    output logic       clk_en,
    output logic [1:0] ratio,
    output logic       ready,
    output logic       hold_pd
);

    localparam int CW = $clog2(TIMEOUT + 1);

    mrd_state_t    st_q, st_d;
    logic [1:0]    cand_q, cand_d;
    logic          rise;
    logic          tmo;
    logic [CW-1:0] meas;
    logic [1:0]    code;
    logic          locked;

    mrd_lr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lr_in  (lr_clk),
        .rise_o (rise)
    );

    mrd_period_cnt #(.TIMEOUT(TIMEOUT), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st_q == ST_OFF),
        .rise   (rise),
        .meas_o (meas),
        .tmo_o  (tmo)
    );

    mrd_classify #(.BASE(BASE), .TOL(TOL), .CW(CW)) u_cls (
        .meas   (meas),
        .code_o (code)
    );

    // next-state logic
    always_comb begin
        st_d   = st_q;
        cand_d = cand_q;
        if (!run) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: st_d = ST_WAIT;
                ST_WAIT: begin
                    if (rise) st_d = ST_MEASURE;
                end
                ST_MEASURE: begin
                    if (rise) begin
                        if (code != RT_BAD) begin
                            st_d   = ST_CONFIRM;
                            cand_d = code;
                        end
                    end else if (tmo) begin
                        st_d = ST_WAIT;
                    end
                end
                ST_CONFIRM: begin
                    if (rise) begin
                        if (code == RT_BAD) begin
                            st_d = ST_MEASURE;
                        end else if (code == cand_q) begin
                            st_d = ST_LOCKED;
                        end else begin
                            cand_d = code;
                        end
                    end else if (tmo) begin
                        st_d = ST_WAIT;
                    end
                end
                ST_LOCKED: begin
                    if (rise) begin
                        if (code == RT_BAD) begin
                            st_d = ST_MEASURE;
                        end else if (code != cand_q) begin
                            st_d   = ST_CONFIRM;
                            cand_d = code;
                        end
                    end else if (tmo) begin
                        st_d = ST_WAIT;
                    end
                end
                default: st_d = ST_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            cand_q <= RT_BAD;
        end else begin
            st_q   <= st_d;
            cand_q <= cand_d;
        end
    end

    assign locked = (st_q == ST_LOCKED);

    mrd_en_gen u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (locked),
        .code   (cand_q),
        .en_o   (clk_en)
    );

    // outputs
    always_comb begin
        ready   = locked;
        ratio   = locked ? cand_q : RT_BAD;
        hold_pd = ~locked;
    end

    AST_PD_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!ready && !clk_en)); // R8

    AST_READY_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rise)); // R4

    AST_CAND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONFIRM || st_q == ST_LOCKED) |-> (cand_q != RT_BAD)); // R3

    AST_TMO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tmo && !rise && st_q != ST_OFF && st_q != ST_WAIT) |=> !ready); // R7

    AST_EN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == RT_BAD) |-> !clk_en); // R6

endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       lr_clk;
    logic       clk_en;
    logic [1:0] ratio;
    logic       ready;
    logic       hold_pd;

    int n_chk = 0;
    int n_bad = 0;
    int gen_period = 0;

    always #(CLK_P / 2) clk = ~clk;

    mclk_ratio_detect u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .lr_clk  (lr_clk),
        .clk_en  (clk_en),
        .ratio   (ratio),
        .ready   (ready),
        .hold_pd (hold_pd)
    );

    // frame clock generator: period in master cycles, 0 = held low
    initial begin
        int ph;
        int last;
        ph = 0;
        last = 0;
        lr_clk = 1'b0;
        forever begin
            @(negedge clk);
            if (gen_period == 0) begin
                lr_clk = 1'b0;
                last = 0;
            end else begin
                if (gen_period != last) begin
                    ph = 0;
                    last = gen_period;
                end
                lr_clk = (ph < gen_period / 2);
                ph = (ph == gen_period - 1) ? 0 : ph + 1;
            end
        end
    end

    function automatic int nominal(input int idx);
        return 256 * (2 + idx) / 2;
    endfunction

    function automatic int exp_en(input int idx, input int win);
        if (idx == 0) return win;
        if (idx == 1) return win * 2 / 3;
        return win / 2;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_en(input int win, output int c);
        c = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (clk_en) c++;
        end
    endtask

    // restart from idle, run a frame clock of nominal(idx)+off, check lock result
    task automatic lock_run(input int idx, input int off, input int dly);
        int n;
        int c;
        bit good;
        n = nominal(idx) + off;
        good = (off >= -2 && off <= 2);
        run = 1'b0;
        gen_period = 0;
        cyc(4);
        run = 1'b1;
        cyc(dly);
        gen_period = n;
        cyc(2 * n - 6);
        if (good) chk("R4 ready low before third edge", ready, 0);
        cyc(16);
        chk("R2/R3/R10 ready", ready, good ? 1 : 0);
        chk("R2/R3 ratio code", ratio, good ? idx : 3);
        chk("R9 hold_pd", hold_pd, good ? 0 : 1);
        count_en(24, c);
        if (good) chk("R5 enable count", c, exp_en(idx, 24));
        else      chk("R6 enable idle", c, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        void'($urandom(32'd20240611));
        cyc(5);
        // R1 reset state
        chk("R1 ready", ready, 0);
        chk("R1 ratio", ratio, 3);
        chk("R1 clk_en", clk_en, 0);
        chk("R1 hold_pd", hold_pd, 1);
        rst_n = 1'b1;
        cyc(3);

        // directed nominal and edge-of-window lengths
        for (int i = 0; i < 3; i++) lock_run(i, 0, 3);
        lock_run(0, 2, 1);
        lock_run(2, -2, 5);
        lock_run(1, 3, 2);
        lock_run(1, -3, 2);

        // constrained random: ratio, offset -6..6, start delay (R10)
        for (int k = 0; k < 14; k++) begin
            int idx;
            int off;
            idx = int'($urandom_range(2, 0));
            off = int'($urandom_range(12, 0)) - 6;
            lock_run(idx, off, int'($urandom_range(9, 0)));
        end

        // R7 timeout
        lock_run(0, 0, 2);
        gen_period = 0;
        cyc(700);
        chk("R7 ready kept before timeout", ready, 1);
        cyc(400);
        chk("R7 ready dropped after timeout", ready, 0);
        chk("R9 hold_pd after timeout", hold_pd, 1);

        // R11 ratio change while locked
        lock_run(0, 0, 2);
        gen_period = 384;
        cyc(3 * 384 + 40);
        chk("R11 relock ready", ready, 1);
        chk("R11 relock ratio", ratio, 1);
        count_en(24, c);
        chk("R11 R5 enable count after relock", c, 16);

        // R8 power-down while clocks keep running
        lock_run(2, 0, 4);
        run = 1'b0;
        cyc(1);
        chk("R8 ready after run low", ready, 0);
        chk("R8 clk_en after run low", clk_en, 0);
        count_en(2000, c);
        chk("R8 no enable while idle", c, 0);
        chk("R8 ready still low", ready, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule